// File: doc/BRIEF.md
# Virtual Interrupt Signaling Controller

This block sits between a guest's view of interrupt handling and the logic that picks the most urgent pending virtual interrupt. A separate prioritizer presents one candidate at a time: its identifier, its eight-bit priority and its group (0 or 1). The block holds a small control register and two binary-point registers. From these it decides whether the candidate may be signaled, and on which processor line: the normal interrupt line or the fast interrupt line.

Software reaches the block through one register access port. Reading the acknowledge location returns an identifier and may make the candidate active. Writing the end-of-interrupt location retires the running priority. Writing the deactivate location clears an identifier's active state. Each retirement step leaves the block as a one-cycle pulse that carries the identifier, so the surrounding logic can update its list of interrupts. Active priorities are held in a small stack. A candidate preempts only if its group priority is strictly more urgent than the top of that stack.

The access port has no back-pressure. The block takes one access in every cycle in which a strobe is high. If both strobes are high, the write is performed and the read is dropped. Read data always returns exactly one cycle after the read strobe, marked by `acc_rvalid`.

Top module: `virq_cpu_if`

## Requirements
- R1: Location 0 is the control register. Only bits 0, 1, 2, 3, 4 and 9 can be written. All other bits read as 0, and writing them has no effect.
- R2: Control bit 0 enables signaling of group 0 and bit 1 enables group 1. When a group's enable bit is 0, a candidate of that group never raises `irq_o` or `fiq_o`.
- R3: A signaled group 0 candidate drives `fiq_o` when control bit 3 is 1 and `irq_o` when bit 3 is 0. A group 1 candidate always drives `irq_o`. The two lines are never high together.
- R4: Reading location 3 (acknowledge) or location 6 (query) while the signaled candidate is group 1 and control bit 2 is 0 returns 1022 and activates nothing. When bit 2 is 1, both reads return the candidate's identifier, and only the acknowledge read makes it active.
- R5: While control bit 9 is 0, a write to location 4 (end of interrupt) that finds an active priority produces a drop pulse and a deactivate pulse in the same cycle, both carrying `acc_wdata[ID_W-1:0]`. Writes to location 5 are ignored.
- R6: While control bit 9 is 1, a write to location 4 produces only a drop pulse. A write to location 5 produces only a deactivate pulse, carrying `acc_wdata[ID_W-1:0]`.
- R7: Acknowledging pushes the candidate's group priority onto a four-entry stack. The top entry is the running priority, and an empty stack means 0xFF. A write to location 4 pops one entry. With the stack empty it produces no pulse. With the stack full, nothing is signaled.
- R8: An acknowledge or query read with no signaled candidate returns 1023.
- R9: After reset, all control and binary-point bits are 0, the stack is empty, both lines are low and no pulse is produced.
- R10: The group priority is the priority ANDed with 0xFF shifted left by the binary point. Location 1 holds the main binary point and location 2 the alternate one, each 3 bits wide. Group 0 uses the main value. Group 1 uses the main value when control bit 4 is 1 and the alternate value when it is 0. A candidate is signaled only if its group priority is numerically below the running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | 3 | Register location |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with `acc_rvalid` |
| acc_rvalid | output | 1 | Read data returned this cycle |
| cand_vld | input | 1 | A candidate is present |
| cand_id | input | ID_W | Candidate identifier |
| cand_prio | input | PRIO_W | Candidate priority, lower is more urgent |
| cand_grp | input | 1 | Candidate group |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| drop_vld | output | 1 | Priority drop pulse |
| drop_id | output | ID_W | Identifier of the drop |
| deact_vld | output | 1 | Deactivate pulse |
| deact_id | output | ID_W | Identifier to deactivate |

## Verification
Read data and both completion pulses appear one clock edge after the access that causes them. The two lines follow a candidate change after one edge. They follow a register write or a stack change after two edges, because the new state must first be registered before the line register sees it. The bench therefore drives every input on a falling edge. It reads data and pulses on the next falling edge, and it judges the lines only after waiting two falling edges. The expected lines and identifiers come from the bench's own arithmetic model of the enables, the routing, the binary-point masks and the stack.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int CTRL_W = 32;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_BPM   = 3'd1;
  localparam logic [2:0] ADR_BPA   = 3'd2;
  localparam logic [2:0] ADR_ACK   = 3'd3;
  localparam logic [2:0] ADR_EOI   = 3'd4;
  localparam logic [2:0] ADR_DEACT = 3'd5;
  localparam logic [2:0] ADR_HPQ   = 3'd6;

  localparam int BIT_EN0   = 0;
  localparam int BIT_EN1   = 1;
  localparam int BIT_SHOW1 = 2;
  localparam int BIT_FAST0 = 3;
  localparam int BIT_SHARE = 4;
  localparam int BIT_SPLIT = 9;

  localparam int ID_HIDDEN = 1022;
  localparam int ID_NONE   = 1023;

  typedef struct packed {
    logic split;
    logic share_bp;
    logic fast0;
    logic show1;
    logic en1;
    logic en0;
  } ctrl_t;
endpackage

// File: rtl/virq_ctrl_regs.sv
module virq_ctrl_regs
  import virq_pkg::*;
#(
  parameter int BP_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  output ctrl_t               ctrl,
  output logic [BP_W-1:0]     bp_main,
  output logic [BP_W-1:0]     bp_alias,
  output logic [CTRL_W-1:0]   ctrl_word
);
  wire unused_rsvd = &{1'b0, wr_data[CTRL_W-1:BIT_SPLIT+1],
                       wr_data[BIT_SPLIT-1:BIT_SHARE+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      bp_main  <= '0;
      bp_alias <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          ctrl.en0      <= wr_data[BIT_EN0];
          ctrl.en1      <= wr_data[BIT_EN1];
          ctrl.show1    <= wr_data[BIT_SHOW1];
          ctrl.fast0    <= wr_data[BIT_FAST0];
          ctrl.share_bp <= wr_data[BIT_SHARE];
          ctrl.split    <= wr_data[BIT_SPLIT];
        end
        ADR_BPM: bp_main  <= wr_data[BP_W-1:0];
        ADR_BPA: bp_alias <= wr_data[BP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_EN0]   = ctrl.en0;
    ctrl_word[BIT_EN1]   = ctrl.en1;
    ctrl_word[BIT_SHOW1] = ctrl.show1;
    ctrl_word[BIT_FAST0] = ctrl.fast0;
    ctrl_word[BIT_SHARE] = ctrl.share_bp;
    ctrl_word[BIT_SPLIT] = ctrl.split;
  end
endmodule

// File: rtl/virq_prio_stack.sv
module virq_prio_stack #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_val,
  output logic [PRIO_W-1:0] running,
  output logic              empty,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  top_idx;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_idx = cnt - 1'b1;
  assign running = empty ? '1 : mem[top_idx[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[cnt[PTR_W-1:0]] <= push_val;
    end
  end
endmodule

// File: rtl/virq_select.sv
module virq_select #(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3
) (
  input  logic              cand_vld,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_grp,
  input  logic              en0,
  input  logic              en1,
  input  logic              fast0,
  input  logic              share_bp,
  input  logic [BP_W-1:0]   bp_main,
  input  logic [BP_W-1:0]   bp_alias,
  input  logic [PRIO_W-1:0] running,
  input  logic              stk_full,
  output logic [PRIO_W-1:0] grp_prio,
  output logic              eligible,
  output logic              to_irq,
  output logic              to_fiq
);
  logic [BP_W-1:0]   bp_sel;
  logic [PRIO_W-1:0] mask;
  logic              grp_en;

  always_comb begin
    bp_sel   = (cand_grp && !share_bp) ? bp_alias : bp_main;
    mask     = {PRIO_W{1'b1}} << bp_sel;
    grp_prio = cand_prio & mask;
    grp_en   = cand_grp ? en1 : en0;
    eligible = cand_vld && grp_en && !stk_full && (grp_prio < running);
    to_fiq   = eligible && !cand_grp && fast0;
    to_irq   = eligible && !to_fiq;
  end
endmodule

// File: rtl/virq_cpu_if.sv
module virq_cpu_if
  import virq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [2:0]        acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_rvalid,
  input  logic              cand_vld,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_grp,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              drop_vld,
  output logic [ID_W-1:0]   drop_id,
  output logic              deact_vld,
  output logic [ID_W-1:0]   deact_id
);
  ctrl_t             ctrl_q;
  logic [BP_W-1:0]   bp_main, bp_alias;
  logic [31:0]       ctrl_word;
  logic              mode_en0, mode_en1, mode_fast0, mode_split;
  logic [PRIO_W-1:0] running, grp_prio;
  logic              stk_empty, stk_full;
  logic              eligible, to_irq, to_fiq;
  logic              rd_fire, hidden, push, pop;
  logic              eoi_wr, deact_wr;
  logic [ID_W-1:0]   resp_id, wr_id;
  logic [31:0]       rd_mux;

  assign mode_en0   = ctrl_q.en0;
  assign mode_en1   = ctrl_q.en1;
  assign mode_fast0 = ctrl_q.fast0;
  assign mode_split = ctrl_q.split;

  virq_ctrl_regs #(.BP_W(BP_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc_wr),
    .wr_addr  (acc_addr),
    .wr_data  (acc_wdata),
    .ctrl     (ctrl_q),
    .bp_main  (bp_main),
    .bp_alias (bp_alias),
    .ctrl_word(ctrl_word)
  );

  virq_select #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_sel (
    .cand_vld (cand_vld),
    .cand_prio(cand_prio),
    .cand_grp (cand_grp),
    .en0      (mode_en0),
    .en1      (mode_en1),
    .fast0    (mode_fast0),
    .share_bp (ctrl_q.share_bp),
    .bp_main  (bp_main),
    .bp_alias (bp_alias),
    .running  (running),
    .stk_full (stk_full),
    .grp_prio (grp_prio),
    .eligible (eligible),
    .to_irq   (to_irq),
    .to_fiq   (to_fiq)
  );

  virq_prio_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (pop),
    .push_val(grp_prio),
    .running (running),
    .empty   (stk_empty),
    .full    (stk_full)
  );

  always_comb begin
    rd_fire  = acc_rd && !acc_wr;
    hidden   = eligible && cand_grp && !ctrl_q.show1;
    wr_id    = acc_wdata[ID_W-1:0];
    eoi_wr   = acc_wr && (acc_addr == ADR_EOI);
    deact_wr = acc_wr && (acc_addr == ADR_DEACT);
    pop      = eoi_wr && !stk_empty;
    push     = rd_fire && (acc_addr == ADR_ACK) && eligible && !hidden;
    if (!eligible)   resp_id = ID_W'(ID_NONE);
    else if (hidden) resp_id = ID_W'(ID_HIDDEN);
    else             resp_id = cand_id;
    case (acc_addr)
      ADR_CTRL:         rd_mux = ctrl_word;
      ADR_BPM:          rd_mux = {{(32-BP_W){1'b0}}, bp_main};
      ADR_BPA:          rd_mux = {{(32-BP_W){1'b0}}, bp_alias};
      ADR_ACK, ADR_HPQ: rd_mux = {{(32-ID_W){1'b0}}, resp_id};
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
      drop_vld   <= 1'b0;
      drop_id    <= '0;
      deact_vld  <= 1'b0;
      deact_id   <= '0;
    end else begin
      acc_rvalid <= rd_fire;
      acc_rdata  <= rd_fire ? rd_mux : '0;
      irq_o      <= to_irq;
      fiq_o      <= to_fiq;
      drop_vld   <= pop;
      deact_vld  <= (pop && !mode_split) || (deact_wr && mode_split);
      if (pop) drop_id <= wr_id;
      if ((pop && !mode_split) || (deact_wr && mode_split)) deact_id <= wr_id;
    end
  end
endmodule

// File: rtl/virq_cpu_if_chk.sv
module virq_cpu_if_chk
  import virq_pkg::*;
#(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            acc_wr,
  input logic            acc_rd,
  input logic [2:0]      acc_addr,
  input logic [31:0]     acc_rdata,
  input logic            acc_rvalid,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            drop_vld,
  input logic [ID_W-1:0] drop_id,
  input logic            deact_vld,
  input logic [ID_W-1:0] deact_id,
  input logic            en0,
  input logic            en1,
  input logic            fast0,
  input logic            split
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(acc_rd && !acc_wr && acc_addr == ADR_CTRL)
      |-> (acc_rdata[31:10] == '0 && acc_rdata[8:5] == '0));

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> $past(en0 || en1));

  p_fast_g0_r3: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(en0 && fast0));

  p_lines_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_o, fiq_o}));

  p_read_return_r4: assert property (@(posedge clk) disable iff (rst)
    $past(acc_rd && !acc_wr) |-> acc_rvalid);

  p_joint_done_r5: assert property (@(posedge clk) disable iff (rst)
    (drop_vld && !$past(split)) |-> (deact_vld && deact_id == drop_id));

  p_deact_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    $past(acc_wr && acc_addr == ADR_DEACT && !split) |-> !deact_vld);

  p_drop_only_r6: assert property (@(posedge clk) disable iff (rst)
    (drop_vld && $past(split)) |-> !deact_vld);
endmodule

bind virq_cpu_if virq_cpu_if_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_wr    (acc_wr),
  .acc_rd    (acc_rd),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .acc_rvalid(acc_rvalid),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .drop_vld  (drop_vld),
  .drop_id   (drop_id),
  .deact_vld (deact_vld),
  .deact_id  (deact_id),
  .en0       (mode_en0),
  .en1       (mode_en1),
  .fast0     (mode_fast0),
  .split     (mode_split)
);

// File: tb/virq_cpu_if_tb.sv
`timescale 1ns/1ps
module virq_cpu_if_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_rvalid;
  logic        cand_vld = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        cand_grp = 1'b0;
  logic        irq_o, fiq_o, drop_vld, deact_vld;
  logic [9:0]  drop_id, deact_id;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  virq_cpu_if dut_i (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .cand_vld(cand_vld), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_grp(cand_grp), .irq_o(irq_o),
    .fiq_o(fiq_o), .drop_vld(drop_vld), .drop_id(drop_id),
    .deact_vld(deact_vld), .deact_id(deact_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p, input logic g);
    @(negedge clk);
    cand_vld = v; cand_id = id; cand_prio = p; cand_grp = g;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq", {31'b0, irq_o}, 0);
    chk("R9 fiq", {31'b0, fiq_o}, 0);
    chk("R9 pulses", {30'b0, drop_vld, deact_vld}, 0);
    rd(3'd0, d); chk("R9 ctrl", d, 0);
    rd(3'd1, d); chk("R9 bp", d, 0);

    // R1 reserved bits
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R1 ctrl mask", d, 32'h0000_021F);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d); chk("R1 ctrl clear", d, 0);

    // R2 / R3 sweep of enables, visibility and routing
    for (int c = 0; c < 16; c++) begin
      for (int g = 0; g < 2; g++) begin
        logic en, ei, ef;
        wr(3'd0, 32'(c));
        cand(1'b1, 10'd33, 8'h40, g[0]);
        settle();
        en = g[0] ? c[1] : c[0];
        ei = en && (g[0] || !c[3]);
        ef = en && !g[0] && c[3];
        chk("R2 R3 irq", {31'b0, irq_o}, {31'b0, ei});
        chk("R2 R3 fiq", {31'b0, fiq_o}, {31'b0, ef});
      end
    end

    // R4 hidden group 1
    wr(3'd0, 32'h3);
    cand(1'b1, 10'd77, 8'h40, 1'b1);
    rd(3'd6, d); chk("R4 query hidden", d, 1022);
    rd(3'd3, d); chk("R4 ack hidden", d, 1022);
    settle(); chk("R4 not activated", {31'b0, irq_o}, 1);
    wr(3'd0, 32'h7);
    rd(3'd6, d); chk("R4 query shown", d, 77);
    rd(3'd3, d); chk("R4 ack shown", d, 77);
    settle(); chk("R7 running blocks same prio", {31'b0, irq_o}, 0);

    // R8 nothing pending
    cand(1'b0, 10'd5, 8'h00, 1'b0);
    rd(3'd3, d); chk("R8 ack none", d, 1023);

    // R5 joint completion, deactivate ignored
    wr(3'd4, 32'd77);
    chk("R5 drop", {31'b0, drop_vld}, 1);
    chk("R5 deact", {31'b0, deact_vld}, 1);
    chk("R5 drop id", {22'b0, drop_id}, 77);
    chk("R5 deact id", {22'b0, deact_id}, 77);
    wr(3'd5, 32'd55);
    chk("R5 deact ignored", {31'b0, deact_vld}, 0);
    wr(3'd4, 32'd12);
    chk("R7 empty eoi", {30'b0, drop_vld, deact_vld}, 0);
    cand(1'b1, 10'd77, 8'h40, 1'b1);
    settle(); chk("R7 idle again", {31'b0, irq_o}, 1);

    // R6 split completion
    wr(3'd0, 32'h207);
    rd(3'd3, d); chk("R6 ack", d, 77);
    wr(3'd4, 32'd77);
    chk("R6 drop", {31'b0, drop_vld}, 1);
    chk("R6 no deact", {31'b0, deact_vld}, 0);
    wr(3'd5, 32'd77);
    chk("R6 deact", {31'b0, deact_vld}, 1);
    chk("R6 deact id", {22'b0, deact_id}, 77);
    chk("R6 no drop", {31'b0, drop_vld}, 0);

    // R7 stack depth
    wr(3'd0, 32'h1);
    for (int k = 0; k < 4; k++) begin
      cand(1'b1, 10'(k + 1), 8'(8'h80 - 8'h20 * k), 1'b0);
      settle(); chk("R7 nested signal", {31'b0, irq_o}, 1);
      rd(3'd3, d); chk("R7 nested ack", d, 32'(k + 1));
    end
    cand(1'b1, 10'd9, 8'h10, 1'b0);
    settle(); chk("R7 full blocks", {31'b0, irq_o}, 0);
    rd(3'd3, d); chk("R7 full ack", d, 1023);
    wr(3'd4, 32'd4);
    chk("R7 pop pulse", {31'b0, drop_vld}, 1);
    settle(); chk("R7 after pop", {31'b0, irq_o}, 1);
    for (int k = 0; k < 3; k++) begin
      wr(3'd4, 32'(3 - k));
      chk("R7 unwind", {22'b0, drop_id}, 32'(3 - k));
    end

    // R10 binary point sweep, shared and alternate
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int bp = 0; bp < 8; bp++) begin
        logic [7:0] m, p0;
        wr(3'd0, cfg == 0 ? 32'h17 : 32'h07);
        wr(3'd1, cfg == 0 ? 32'(bp) : 32'd0);
        wr(3'd2, cfg == 0 ? 32'd0 : 32'(bp));
        m = 8'hFF << bp;
        p0 = 8'h5A;
        cand(1'b1, 10'd200, p0, 1'b1);
        rd(3'd3, d); chk("R10 ack", d, 200);
        for (int q = 0; q < 8; q++) begin
          logic [7:0] qv;
          case (q)
            0: qv = 8'h00; 1: qv = 8'h3F; 2: qv = 8'h50; 3: qv = 8'h58;
            4: qv = 8'h59; 5: qv = 8'h5F; 6: qv = 8'h60; default: qv = 8'hFF;
          endcase
          cand(1'b1, 10'd201, qv, 1'b1);
          settle();
          chk("R10 preempt", {31'b0, irq_o}, {31'b0, (qv & m) < (p0 & m)});
        end
        wr(3'd4, 32'd200);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule